// File: doc/BRIEF.md
# Auxiliary DAC Channel Controller with Profile Ramp

This block produces the digital codes for four auxiliary DAC outputs. A host programs the channels through one 16-bit control word port. Each write addresses a single channel and loads that channel's enable and output code, so refreshing all four outputs takes four writes.

Channel 0 can also run as a ramp generator. In this mode it walks through a 64-entry profile memory and presents each sample on its output in turn. The walk runs upward or downward, and its speed is set by a programmable step divider. The profile memory comes out of reset holding a raised-cosine shape, and a separate write port lets the host replace it.

A ramp may start only while the operating mode is transmit. If the mode leaves transmit part way through a ramp, the sequencer freezes on the current sample and raises an abort flag, so the output does not jump. During powersave, enabled outputs keep their code, disabled outputs read zero, and the ramp pauses.

Top module: `auxdac_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all channels become disabled and static, every output code reads 0, `ramp_active`, `ramp_done` and `ramp_aborted` read 0, and the profile memory is reloaded with its default contents.
- R2: Control word layout: bits 9:0 hold the code, bits 11:10 the channel, bit 12 the ramp request, bit 13 the enable and bit 14 the ramp direction (1 = down). A write loads the enable and code of the addressed channel only. The other three channels keep their enable and code.
- R3: A disabled channel outputs 0. An enabled static channel outputs its last written code, from the clock edge that accepts the write onward.
- R4: After reset, profile entry i (0..63) holds (1023*(189*i*i - 2*i*i*i) + 125023) / 250047 in integer division, a cubic raised-cosine rising from 0 to 1023.
- R5: A write on the profile port at a clock edge replaces entry `prof_addr` with `prof_data`, and later ramps output the new value.
- R6: In transmit mode (`op_mode` = 2'b10), a write to channel 0 with bit 12 set starts a ramp. The ramp starts at entry 0 when bit 14 is 0 and at entry 63 when bit 14 is 1. From the accepting edge onward, channel 0 outputs the current entry and `ramp_active` reads 1.
- R7: While a ramp runs, the entry index moves by one toward the end every `rate_div`+1 clock cycles.
- R8: When the index reaches entry 63 (up) or entry 0 (down), `ramp_done` goes to 1 and `ramp_active` to 0, and the output holds the end entry. The next write to channel 0 clears `ramp_done`.
- R9: A write to channel 0 with bit 12 set while the mode is idle (2'b00), receive (2'b01) or 2'b11 is ignored completely, including its enable bit.
- R10: If the mode is not transmit while a ramp is active, then at the next edge the index freezes, `ramp_active` drops and `ramp_aborted` goes to 1. The output stays on the frozen entry. The next write to channel 0 clears the flag.
- R11: While `powersave` is high, the ramp index does not advance. With no writes, every output stays unchanged and disabled channels read 0.
- R12: A write to channel 0 with bit 12 clear returns channel 0 to static mode with the new code. It stops any running ramp and clears `ramp_done` and `ramp_aborted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_word | input | 16 | Control word (channel, enable, ramp request, direction, code) |
| prof_we | input | 1 | Profile memory write strobe |
| prof_addr | input | 6 | Profile entry to write |
| prof_data | input | 10 | Profile sample value |
| op_mode | input | 2 | Operating mode: 00 idle, 01 receive, 10 transmit, 11 treated as idle |
| powersave | input | 1 | Powersave: hold outputs, pause ramp |
| rate_div | input | 16 | Ramp step period minus one, in clock cycles |
| dac_code | output | 40 | Four 10-bit output codes, channel k in bits 10k+9:10k |
| ramp_active | output | 1 | Ramp in progress |
| ramp_done | output | 1 | Ramp reached its end entry |
| ramp_aborted | output | 1 | Ramp frozen because the mode left transmit |

## Verification
The output codes are combinational reads of the state registers, so a wrong index, divider count or stored sample shows on `dac_code` in the cycle after the edge that stored it. A miscounting divider offsets every later step, and within one step period the output no longer matches the sample the bench expects for that cycle. A lost freeze on abort or on powersave shows as an output that moves in a cycle where it should be stable. A wrong channel decode shows as a change on a channel that was not addressed.

// File: rtl/auxdac_pkg.sv
`timescale 1ns/1ps
// Package: shared mode encoding, control word fields and the default
// profile formula. Assumes a 10-bit code field at the bottom of the word.
package auxdac_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_RX   = 2'b01,
        MODE_TX   = 2'b10,
        MODE_RSVD = 2'b11
    } op_mode_e;

    localparam int CW_WIDTH  = 16;
    localparam int CW_SEL_LO = 10;
    localparam int CW_RAMP   = 12;
    localparam int CW_EN     = 13;
    localparam int CW_DIR    = 14;

    // Cubic raised-cosine sample i of a table whose last index is last.
    function automatic int unsigned rc_sample(int unsigned i, int unsigned last,
                                              int unsigned full);
        longint num;
        longint den;
        den = longint'(last) * last * last;
        num = longint'(full) * (3 * longint'(i) * i * last - 2 * longint'(i) * i * i);
        return int'((num + den / 2) / den);
    endfunction

endpackage

// File: rtl/auxdac_profile_ram.sv
`timescale 1ns/1ps
// Profile memory: 2**AW entries of DW bits. Reset loads the raised-cosine
// default. One write port and one asynchronous read port.
// Assumes the reset is held for at least one clock edge.
module auxdac_profile_ram #(
    parameter int DW = 10,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    import auxdac_pkg::*;

    localparam int DEPTH = 1 << AW;
    localparam int FULL  = (1 << DW) - 1;

    logic [DW-1:0] mem_q [DEPTH];

    // Reload the default shape on reset, else take host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= DW'(rc_sample(i, DEPTH - 1, FULL));
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Read the sample the sequencer points at.
    assign rd_data = mem_q[rd_addr];

    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/auxdac_chan_regs.sv
`timescale 1ns/1ps
// Channel registers: enable and static code per channel, plus the ramp
// mode flag of channel 0. Assumes the write strobe arriving here has
// already been filtered for illegal ramp requests.
module auxdac_chan_regs #(
    parameter int NCH = 4,
    parameter int DW  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NCH)-1:0]  sel,
    input  logic                    en_bit,
    input  logic                    ramp_bit,
    input  logic [DW-1:0]           data,
    output logic [NCH-1:0][DW-1:0]  level,
    output logic [NCH-1:0]          enable,
    output logic                    ramp_mode
);
    localparam int SW = $clog2(NCH);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        // Load this channel's enable and code when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                level[k]  <= '0;
                enable[k] <= 1'b0;
            end else if (we && sel == SW'(k)) begin
                enable[k] <= en_bit;
                if (!(k == 0 && ramp_bit)) begin
                    level[k] <= data;
                end
            end
        end

        a_r2_other_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel != SW'(k)) |=> ($stable(level[k]) && $stable(enable[k])));
    end

    // Channel 0 source select: static code or profile ramp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ramp_mode <= 1'b0;
        end else if (we && sel == '0) begin
            ramp_mode <= ramp_bit;
        end
    end

endmodule

// File: rtl/auxdac_ramp_seq.sv
`timescale 1ns/1ps
// Ramp sequencer: walks the profile index up or down, one step per
// divider terminal count. Freezes on leaving transmit and during
// powersave. Assumes start is only raised in transmit mode.
module auxdac_ramp_seq #(
    parameter int AW = 6,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_down,
    input  logic          cancel,
    input  logic          tx_mode,
    input  logic          powersave,
    input  logic [RW-1:0] rate_div,
    output logic [AW-1:0] idx,
    output logic          active,
    output logic          done,
    output logic          aborted
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    logic [RW-1:0] cnt_q;
    logic          down_q;
    logic [AW-1:0] idx_next;
    logic [AW-1:0] idx_end;

    // Next index and the end point of the current direction.
    always_comb begin
        idx_next = down_q ? idx - AW'(1) : idx + AW'(1);
        idx_end  = down_q ? '0 : LAST;
    end

    // Sequencer state: start, cancel, abort, pause and stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            cnt_q   <= '0;
            down_q  <= 1'b0;
            active  <= 1'b0;
            done    <= 1'b0;
            aborted <= 1'b0;
        end else if (start) begin
            idx     <= dir_down ? LAST : '0;
            cnt_q   <= '0;
            down_q  <= dir_down;
            active  <= 1'b1;
            done    <= 1'b0;
            aborted <= 1'b0;
        end else if (cancel) begin
            active  <= 1'b0;
            done    <= 1'b0;
            aborted <= 1'b0;
        end else if (active) begin
            if (!tx_mode) begin
                active  <= 1'b0;
                aborted <= 1'b1;
            end else if (!powersave) begin
                if (cnt_q == rate_div) begin
                    cnt_q <= '0;
                    idx   <= idx_next;
                    if (idx_next == idx_end) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + RW'(1);
                end
            end
        end
    end

    a_r8_done_not_active: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !done);

    a_r10_abort_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tx_mode && !start && !cancel) |=> (!active && aborted && $stable(idx)));

    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start) |=> (idx == $past(idx) || idx == $past(idx) + AW'(1)
                                || idx == $past(idx) - AW'(1)));

    a_r11_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (powersave && !start) |=> $stable(idx));

endmodule

// File: rtl/auxdac_ctrl.sv
`timescale 1ns/1ps
// Top: four auxiliary DAC code outputs behind one control word port,
// with a profile ramp on channel 0. Outputs are digital codes only.
// Assumes op_mode and powersave are synchronous to clk.
module auxdac_ctrl #(
    parameter int NCH = 4,
    parameter int DW  = 10,
    parameter int AW  = 6,
    parameter int RW  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [15:0]        ctrl_word,
    input  logic               prof_we,
    input  logic [AW-1:0]      prof_addr,
    input  logic [DW-1:0]      prof_data,
    input  logic [1:0]         op_mode,
    input  logic               powersave,
    input  logic [RW-1:0]      rate_div,
    output logic [NCH*DW-1:0]  dac_code,
    output logic               ramp_active,
    output logic               ramp_done,
    output logic               ramp_aborted
);
    import auxdac_pkg::*;

    localparam int SW = $clog2(NCH);

    logic [SW-1:0]          w_sel;
    logic                   w_ramp;
    logic                   w_en;
    logic                   w_dir;
    logic [DW-1:0]          w_data;
    logic                   is_tx;
    logic                   wr_ok;
    logic                   ramp_start;
    logic                   ramp_cancel;
    logic [NCH-1:0][DW-1:0] level;
    logic [NCH-1:0]         enable;
    logic                   ramp_mode;
    logic [AW-1:0]          ramp_idx;
    logic [DW-1:0]          prof_sample;

    // Split the control word and filter ramp requests outside transmit.
    always_comb begin
        w_sel       = ctrl_word[CW_SEL_LO +: SW];
        w_ramp      = ctrl_word[CW_RAMP];
        w_en        = ctrl_word[CW_EN];
        w_dir       = ctrl_word[CW_DIR];
        w_data      = ctrl_word[DW-1:0];
        is_tx       = (op_mode == MODE_TX);
        wr_ok       = ctrl_we && !(w_sel == '0 && w_ramp && !is_tx);
        ramp_start  = wr_ok && w_sel == '0 && w_ramp;
        ramp_cancel = wr_ok && w_sel == '0 && !w_ramp;
    end

    auxdac_chan_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_ok),
        .sel       (w_sel),
        .en_bit    (w_en),
        .ramp_bit  (w_ramp),
        .data      (w_data),
        .level     (level),
        .enable    (enable),
        .ramp_mode (ramp_mode)
    );

    auxdac_ramp_seq #(.AW(AW), .RW(RW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ramp_start),
        .dir_down  (w_dir),
        .cancel    (ramp_cancel),
        .tx_mode   (is_tx),
        .powersave (powersave),
        .rate_div  (rate_div),
        .idx       (ramp_idx),
        .active    (ramp_active),
        .done      (ramp_done),
        .aborted   (ramp_aborted)
    );

    auxdac_profile_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prof_we),
        .wr_addr (prof_addr),
        .wr_data (prof_data),
        .rd_addr (ramp_idx),
        .rd_data (prof_sample)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_out
        // Pick the channel source and force zero when disabled.
        always_comb begin
            if (!enable[k]) begin
                dac_code[k*DW +: DW] = '0;
            end else if (k == 0 && ramp_mode) begin
                dac_code[k*DW +: DW] = prof_sample;
            end else begin
                dac_code[k*DW +: DW] = level[k];
            end
        end
    end

    a_r9_no_ramp_outside_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && w_sel == '0 && w_ramp && !is_tx && !prof_we) |=> $stable(dac_code));

    a_r11_ps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (powersave && !ctrl_we && !prof_we) |=> $stable(dac_code));

endmodule

// File: tb/tb_auxdac_ctrl.sv
`timescale 1ns/1ps
module tb_auxdac_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_word = '0;
    logic        prof_we = 1'b0;
    logic [5:0]  prof_addr = '0;
    logic [9:0]  prof_data = '0;
    logic [1:0]  op_mode = 2'b00;
    logic        powersave = 1'b0;
    logic [15:0] rate_div = '0;
    logic [39:0] dac_code;
    logic        ramp_active;
    logic        ramp_done;
    logic        ramp_aborted;

    int checks = 0;
    int errors = 0;
    int exp_prof [64];
    int lvl [4];
    int en_m [4];

    always #4 clk = ~clk;

    auxdac_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_word(ctrl_word),
        .prof_we(prof_we), .prof_addr(prof_addr), .prof_data(prof_data),
        .op_mode(op_mode), .powersave(powersave), .rate_div(rate_div),
        .dac_code(dac_code), .ramp_active(ramp_active), .ramp_done(ramp_done),
        .ramp_aborted(ramp_aborted)
    );

    function automatic int out(input int k);
        return int'(dac_code[k*10 +: 10]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input int ch, input int en, input int ramp, input int dir,
                           input int data);
        ctrl_word = {1'b0, dir[0], en[0], ramp[0], ch[1:0], data[9:0]};
        ctrl_we = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
        if (!(ch == 0 && ramp != 0 && op_mode != 2'b10)) begin
            en_m[ch] = en;
            if (!(ch == 0 && ramp != 0)) lvl[ch] = data;
        end
    endtask

    task automatic chk_static(input string req, input int from);
        for (int k = from; k < 4; k++) begin
            chk(req, out(k), (en_m[k] != 0) ? lvl[k] : 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            exp_prof[i] = (1023 * (189 * i * i - 2 * i * i * i) + 125023) / 250047;
        end
        for (int k = 0; k < 4; k++) begin
            lvl[k] = 0;
            en_m[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 dac_code", int'(dac_code == 0), 1);
        chk("R1 active", ramp_active, 0);
        chk("R1 done", ramp_done, 0);
        chk("R1 aborted", ramp_aborted, 0);

        // R2 R3: static sweep, one channel per write
        for (int v = 0; v < 6; v++) begin
            for (int ch = 0; ch < 4; ch++) begin
                wr_ctrl(ch, 1, 0, 0, (v * 181 + ch * 97 + 1) % 1024);
                chk_static("R2 static sweep", 0);
            end
        end
        wr_ctrl(2, 0, 0, 0, 18);
        chk("R3 disabled zero", out(2), 0);
        chk_static("R2 others kept", 0);
        wr_ctrl(3, 1, 0, 0, 1023);
        chk("R3 full scale", out(3), 1023);

        // R4 R6 R8: default profile, upward ramp, one step per cycle
        op_mode = 2'b10;
        rate_div = 16'd0;
        wr_ctrl(0, 1, 1, 0, 0);
        chk("R6 active after start", ramp_active, 1);
        for (int k = 0; k < 64; k++) begin
            chk("R4 default profile", out(0), exp_prof[k]);
            if (k == 63) begin
                chk("R8 done", ramp_done, 1);
                chk("R8 active clear", ramp_active, 0);
            end
            @(negedge clk);
        end
        chk("R8 hold end", out(0), exp_prof[63]);
        chk_static("R2 ramp leaves others", 1);

        // R5 R7: rewritten profile, downward ramp at rate_div=2
        for (int i = 0; i < 64; i++) begin
            prof_we = 1'b1;
            prof_addr = 6'(i);
            prof_data = 10'((i * 37 + 5) % 1024);
            exp_prof[i] = (i * 37 + 5) % 1024;
            @(negedge clk);
        end
        prof_we = 1'b0;
        rate_div = 16'd2;
        wr_ctrl(0, 1, 1, 1, 0);
        chk("R8 done cleared", ramp_done, 0);
        for (int n = 0; n < 190; n++) begin
            chk("R7 R5 down ramp", out(0), exp_prof[63 - n / 3]);
            if (n == 189) chk("R8 done down", ramp_done, 1);
            @(negedge clk);
        end

        // R10: leave transmit mid-ramp
        rate_div = 16'd0;
        wr_ctrl(0, 1, 1, 0, 0);
        repeat (10) @(negedge clk);
        op_mode = 2'b01;
        @(negedge clk);
        chk("R10 frozen", out(0), exp_prof[10]);
        chk("R10 aborted", ramp_aborted, 1);
        chk("R10 inactive", ramp_active, 0);
        repeat (4) @(negedge clk);
        chk("R10 still frozen", out(0), exp_prof[10]);

        // R9: ramp request outside transmit ignored, enable bit too
        wr_ctrl(0, 0, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk("R9 output kept", out(0), exp_prof[10]);
        chk("R9 no start", ramp_active, 0);
        chk("R9 abort kept", ramp_aborted, 1);

        // R12: static write returns channel 0 to static mode
        op_mode = 2'b10;
        wr_ctrl(0, 1, 0, 0, 677);
        chk("R12 static code", out(0), 677);
        chk("R12 abort cleared", ramp_aborted, 0);

        // R11: powersave pauses ramp and holds outputs
        wr_ctrl(0, 1, 1, 0, 0);
        repeat (5) @(negedge clk);
        powersave = 1'b1;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk("R11 ramp paused", out(0), exp_prof[5]);
            chk("R11 disabled zero", out(2), 0);
            chk("R11 enabled hold", out(1), lvl[1]);
        end
        powersave = 1'b0;
        @(negedge clk);
        chk("R11 resumes", out(0), exp_prof[6]);

        // R12: static write stops a running ramp
        wr_ctrl(0, 1, 0, 0, 300);
        chk("R12 cancel active", ramp_active, 0);
        repeat (3) @(negedge clk);
        chk("R12 static after cancel", out(0), 300);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule